// File: doc/BRIEF.md
# PCI Configuration Register Block for an I/O Function

This block holds the target-side configuration registers of a PCI function that lives in I/O space. Configuration accesses arrive as a DWORD index, four byte enables, a write strobe and write data. Read data is returned combinationally for the current index. Writes take effect at the next rising clock edge.

The block keeps four sticky error flags in the upper half of the status register. It also keeps a writable command byte, the cache line size and latency timer bytes, and a board strap byte that is captured while reset is held. A single I/O base address register claims a 32-byte window. A separate I/O address input is compared against that register, and on a hit the block reports the DWORD offset inside the window. The bus protocol sequencer and the data path sit outside and drive the event inputs.

Top module: `pci_cfg_regs`

## Requirements
- R1: After reset, index 1 reads 0x00000000, index 3 reads 0x00000000 and index 4 (the base register) reads 0x00000001.
- R2: A pulse on the target-abort, master-abort or SERR event input sets bit 28, 29 or 30 of index 1 respectively, visible from the clock edge that samples it.
- R3: A pulse on the parity-error event input sets bit 31 of index 1 even when the parity-response enable (index 1 bit 6) is 0.
- R4: Bits 31:28 of index 1 are sticky. Writing index 1 with byte enable 3 set and a 1 in one of those bits clears that bit. Writing a 0 leaves the bit as it is. An event in the same cycle as a clear keeps the bit set.
- R5: Index 0x11 reads the 8-bit strap input as sampled at the last clock edge with reset active, in bits 7:0, and 0 in bits 31:8. Writes and later strap changes do not alter it.
- R6: At index 3, byte 0 is the cache line size and byte 1 is the latency timer. Both are writable and reset to 0. Bytes 2 (header type) and 3 (self-test) always read 0.
- R7: At index 4, bits 4:0 always read 0b00001. Bits 31:5 are writable and follow the byte enables.
- R8: io_hit_o is 1 exactly when io_valid_i is 1, index 1 bit 0 (I/O enable) is 1 and address bits 31:5 equal base bits 31:5. io_dw_off_o then equals address bits 4:2.
- R9: At index 1, only bits 0 (I/O enable) and 6 (parity-response enable) of the command half are writable, through byte enable 0. All other command and status bits below 28 read 0.
- R10: A write changes only the bytes whose enable is set. Any index other than 1, 3, 4 and 0x11 reads 0 and ignores writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset; the strap byte is captured while it is low |
| cfg_idx_i | input | IDX_W | Configuration DWORD index |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_be_i | input | 4 | Byte enables for the write |
| cfg_wdata_i | input | 32 | Write data |
| cfg_rdata_o | output | 32 | Read data for cfg_idx_i |
| ev_target_abort_i | input | 1 | Own transaction ended in target abort |
| ev_master_abort_i | input | 1 | Own transaction ended in master abort |
| ev_serr_i | input | 1 | SERR was asserted |
| ev_parity_err_i | input | 1 | Parity error detected |
| strap_i | input | STRAP_W | Board option straps |
| io_valid_i | input | 1 | I/O address is valid for decode |
| io_addr_i | input | 30 | I/O address bits 31:2 |
| io_hit_o | output | 1 | Address falls inside the claimed window |
| io_dw_off_o | output | WIN_LOG2-2 | DWORD offset inside the window |

## Verification
The bench builds the block with its defaults: a 6-bit index, an 8-bit strap bus and a 32-byte window. With these values the board register at index 0x11 and unmapped indices up to 63 can be reached, and the 3-bit offset covers all eight DWORDs of the window. Random traffic aims its base-register writes and I/O addresses near the programmed base, so hits, near misses one window away and every offset occur often. Random events collide with status clears and show that a set wins over a clear.

// File: rtl/pci_cfg_pkg.sv
package pci_cfg_pkg;
  localparam int DW = 32;
  localparam int BW = DW / 8;
  localparam int N_ERR = 4;
  localparam int STS_LSB = 28;           // error flags live at status bits 15:12

  localparam int IDX_CMDSTS = 1;
  localparam int IDX_MISC   = 3;
  localparam int IDX_BAR    = 4;
  localparam int IDX_BOARD  = 17;

  typedef enum int {
    ERR_TGT_ABORT = 0,
    ERR_MST_ABORT = 1,
    ERR_SERR      = 2,
    ERR_PARITY    = 3
  } err_e;

  function automatic logic [DW-1:0] be_mask(input logic [BW-1:0] be);
    logic [DW-1:0] m;
    for (int b = 0; b < BW; b++) m[b*8 +: 8] = {8{be[b]}};
    return m;
  endfunction
endpackage

// File: rtl/pci_cfg_status.sv
module pci_cfg_status
  import pci_cfg_pkg::*;
#(
  parameter int N = N_ERR
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] set_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] sts_o
);
  logic [N-1:0] sts_q;

  for (genvar i = 0; i < N; i++) begin : g_flag
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)       sts_q[i] <= 1'b0;
      else if (set_i[i]) sts_q[i] <= 1'b1;   // event beats clear
      else if (clr_i[i]) sts_q[i] <= 1'b0;
    end
  end

  assign sts_o = sts_q;

  p_set_seen_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (set_i != '0) |=> ((sts_q & $past(set_i)) == $past(set_i)));

  p_parity_sets_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    set_i[ERR_PARITY] |=> sts_q[ERR_PARITY]);

  p_sticky_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> (($past(sts_q) & ~$past(clr_i) & ~sts_q) == '0));

  p_no_spurious_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((sts_q & ~$past(sts_q) & ~$past(set_i)) == '0));
endmodule

// File: rtl/pci_cfg_misc.sv
module pci_cfg_misc #(
  parameter int STRAP_W = 8
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [STRAP_W-1:0] strap_i,
  input  logic               cmd_wr_i,
  input  logic               cmd_io_i,
  input  logic               cmd_par_i,
  input  logic               cls_wr_i,
  input  logic               lt_wr_i,
  input  logic [7:0]         cls_i,
  input  logic [7:0]         lt_i,
  output logic               io_en_o,
  output logic               par_en_o,
  output logic [7:0]         cls_o,
  output logic [7:0]         lt_o,
  output logic [STRAP_W-1:0] board_o
);
  logic               io_en_q, par_en_q;
  logic [7:0]         cls_q, lt_q;
  logic [STRAP_W-1:0] board_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      io_en_q  <= 1'b0;
      par_en_q <= 1'b0;
      cls_q    <= '0;
      lt_q     <= '0;
    end else begin
      if (cmd_wr_i) begin
        io_en_q  <= cmd_io_i;
        par_en_q <= cmd_par_i;
      end
      if (cls_wr_i) cls_q <= cls_i;
      if (lt_wr_i)  lt_q  <= lt_i;
    end
  end

  // straps sampled on every edge while reset is held, frozen afterwards
  always_ff @(posedge clk_i) begin
    if (!rst_ni) board_q <= strap_i;
  end

  assign io_en_o  = io_en_q;
  assign par_en_o = par_en_q;
  assign cls_o    = cls_q;
  assign lt_o     = lt_q;
  assign board_o  = board_q;

  p_board_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> $stable(board_q));

  p_misc_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(cls_wr_i || lt_wr_i) |=> ($stable(cls_q) && $stable(lt_q)));
endmodule

// File: rtl/pci_cfg_bar.sv
module pci_cfg_bar
  import pci_cfg_pkg::*;
#(
  parameter int WIN_LOG2 = 5
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  wr_i,
  input  logic [BW-1:0]         be_i,
  input  logic [DW-1:0]         wdata_i,
  input  logic                  io_en_i,
  input  logic                  io_valid_i,
  input  logic [DW-1:2]         io_addr_i,
  output logic [DW-1:0]         bar_o,
  output logic                  hit_o,
  output logic [WIN_LOG2-3:0]   off_o
);
  localparam logic [WIN_LOG2-1:0] LOW_BITS = WIN_LOG2'(1);  // I/O space indicator

  logic [DW-1:WIN_LOG2] base_q;
  logic [DW-1:0]        mask, merged;

  always_comb begin
    mask   = be_mask(be_i);
    merged = ({base_q, {WIN_LOG2{1'b0}}} & ~mask) | (wdata_i & mask);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   base_q <= '0;
    else if (wr_i) base_q <= merged[DW-1:WIN_LOG2];
  end

  assign bar_o = {base_q, LOW_BITS};
  assign hit_o = io_valid_i && io_en_i && (io_addr_i[DW-1:WIN_LOG2] == base_q);
  assign off_o = io_addr_i[WIN_LOG2-1:2];

  p_hit_needs_enable_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit_o |-> (io_en_i && io_valid_i));

  p_base_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_i |=> $stable(base_q));
endmodule

// File: rtl/pci_cfg_regs.sv
module pci_cfg_regs
  import pci_cfg_pkg::*;
#(
  parameter int IDX_W    = 6,
  parameter int STRAP_W  = 8,
  parameter int WIN_LOG2 = 5
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [IDX_W-1:0]    cfg_idx_i,
  input  logic                cfg_we_i,
  input  logic [3:0]          cfg_be_i,
  input  logic [31:0]         cfg_wdata_i,
  output logic [31:0]         cfg_rdata_o,
  input  logic                ev_target_abort_i,
  input  logic                ev_master_abort_i,
  input  logic                ev_serr_i,
  input  logic                ev_parity_err_i,
  input  logic [STRAP_W-1:0]  strap_i,
  input  logic                io_valid_i,
  input  logic [31:2]         io_addr_i,
  output logic                io_hit_o,
  output logic [WIN_LOG2-3:0] io_dw_off_o
);
  logic sel_cs, sel_misc, sel_bar, sel_board;
  logic [N_ERR-1:0] ev_set, ev_clr, sts;
  logic io_en, par_en;
  logic [7:0] cls, lt;
  logic [STRAP_W-1:0] board;
  logic [DW-1:0] bar;

  assign sel_cs    = cfg_idx_i == IDX_W'(IDX_CMDSTS);
  assign sel_misc  = cfg_idx_i == IDX_W'(IDX_MISC);
  assign sel_bar   = cfg_idx_i == IDX_W'(IDX_BAR);
  assign sel_board = cfg_idx_i == IDX_W'(IDX_BOARD);

  always_comb begin
    ev_set                = '0;
    ev_set[ERR_TGT_ABORT] = ev_target_abort_i;
    ev_set[ERR_MST_ABORT] = ev_master_abort_i;
    ev_set[ERR_SERR]      = ev_serr_i;
    ev_set[ERR_PARITY]    = ev_parity_err_i;   // independent of par_en
    ev_clr = (cfg_we_i && sel_cs && cfg_be_i[3]) ? cfg_wdata_i[STS_LSB +: N_ERR] : '0;
  end

  pci_cfg_status #(.N(N_ERR)) u_status (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .set_i (ev_set),
    .clr_i (ev_clr),
    .sts_o (sts)
  );

  pci_cfg_misc #(.STRAP_W(STRAP_W)) u_misc (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .strap_i  (strap_i),
    .cmd_wr_i (cfg_we_i && sel_cs && cfg_be_i[0]),
    .cmd_io_i (cfg_wdata_i[0]),
    .cmd_par_i(cfg_wdata_i[6]),
    .cls_wr_i (cfg_we_i && sel_misc && cfg_be_i[0]),
    .lt_wr_i  (cfg_we_i && sel_misc && cfg_be_i[1]),
    .cls_i    (cfg_wdata_i[7:0]),
    .lt_i     (cfg_wdata_i[15:8]),
    .io_en_o  (io_en),
    .par_en_o (par_en),
    .cls_o    (cls),
    .lt_o     (lt),
    .board_o  (board)
  );

  pci_cfg_bar #(.WIN_LOG2(WIN_LOG2)) u_bar (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_i      (cfg_we_i && sel_bar),
    .be_i      (cfg_be_i),
    .wdata_i   (cfg_wdata_i),
    .io_en_i   (io_en),
    .io_valid_i(io_valid_i),
    .io_addr_i (io_addr_i),
    .bar_o     (bar),
    .hit_o     (io_hit_o),
    .off_o     (io_dw_off_o)
  );

  always_comb begin
    cfg_rdata_o = '0;
    if (sel_cs) begin
      cfg_rdata_o[STS_LSB +: N_ERR] = sts;
      cfg_rdata_o[6]                = par_en;
      cfg_rdata_o[0]                = io_en;
    end else if (sel_misc) begin
      cfg_rdata_o[15:0] = {lt, cls};
    end else if (sel_bar) begin
      cfg_rdata_o = bar;
    end else if (sel_board) begin
      cfg_rdata_o[STRAP_W-1:0] = board;
    end
  end

  p_low_bits_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sel_bar |-> (cfg_rdata_o[WIN_LOG2-1:0] == WIN_LOG2'(1)));

  p_board_upper_zero_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sel_board |-> (cfg_rdata_o[31:STRAP_W] == '0));
endmodule

// File: tb/pci_cfg_regs_tb.sv
`timescale 1ns/1ps
module pci_cfg_regs_tb;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [5:0]  cfg_idx_i = '0;
  logic        cfg_we_i = 1'b0;
  logic [3:0]  cfg_be_i = '0;
  logic [31:0] cfg_wdata_i = '0;
  logic [31:0] cfg_rdata_o;
  logic        ev_ta, ev_ma, ev_se, ev_pe;
  logic [7:0]  strap_i = 8'hA5;
  logic        io_valid_i = 1'b0;
  logic [31:2] io_addr_i = '0;
  logic        io_hit_o;
  logic [2:0]  io_dw_off_o;

  int n_chk = 0;
  int n_fail = 0;

  // model state
  logic [3:0]  m_sts;
  logic        m_io, m_par;
  logic [7:0]  m_cls, m_lt, m_board;
  logic [26:0] m_base;

  always #2.5 clk_i = ~clk_i;

  pci_cfg_regs u_dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .cfg_idx_i(cfg_idx_i), .cfg_we_i(cfg_we_i),
    .cfg_be_i(cfg_be_i), .cfg_wdata_i(cfg_wdata_i), .cfg_rdata_o(cfg_rdata_o),
    .ev_target_abort_i(ev_ta), .ev_master_abort_i(ev_ma), .ev_serr_i(ev_se),
    .ev_parity_err_i(ev_pe), .strap_i(strap_i), .io_valid_i(io_valid_i),
    .io_addr_i(io_addr_i), .io_hit_o(io_hit_o), .io_dw_off_o(io_dw_off_o)
  );

  function automatic logic [31:0] exp_read(input logic [5:0] idx);
    case (idx)
      6'd1:    return {m_sts, 21'b0, m_par, 5'b0, m_io};
      6'd3:    return {16'b0, m_lt, m_cls};
      6'd4:    return {m_base, 5'b00001};
      6'd17:   return {24'b0, m_board};
      default: return 32'b0;
    endcase
  endfunction

  function automatic string auto_tag(input logic [5:0] idx);
    case (idx)
      6'd1:    return "R4";
      6'd3:    return "R6";
      6'd4:    return "R7";
      6'd17:   return "R5";
      default: return "R10";
    endcase
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", tag, act, exp);
    end
  endtask

  task automatic model_reset(input logic [7:0] strap);
    m_sts = '0; m_io = 0; m_par = 0; m_cls = '0; m_lt = '0; m_base = '0; m_board = strap;
  endtask

  task automatic do_reset(input logic [7:0] strap);
    @(negedge clk_i);
    rst_ni = 1'b0; strap_i = strap;
    cfg_we_i = 0; ev_ta = 0; ev_ma = 0; ev_se = 0; ev_pe = 0; io_valid_i = 0;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    model_reset(strap);
    strap_i = ~strap;   // later strap changes must not be captured
  endtask

  // called just after a negedge: drive, check combinational outputs, then clock
  task automatic apply(input logic [5:0] idx, input logic we, input logic [3:0] be,
                       input logic [31:0] wd, input logic [3:0] ev,
                       input logic iov, input logic [31:2] ioa, input string tag);
    logic [31:0] mk, full;
    logic exp_hit;
    cfg_idx_i = idx; cfg_we_i = we; cfg_be_i = be; cfg_wdata_i = wd;
    {ev_pe, ev_se, ev_ma, ev_ta} = ev;
    io_valid_i = iov; io_addr_i = ioa;
    #1;
    check((tag == "") ? auto_tag(idx) : tag, cfg_rdata_o, exp_read(idx));
    exp_hit = iov && m_io && (ioa[31:5] == m_base);
    check("R8", {31'b0, io_hit_o}, {31'b0, exp_hit});
    if (exp_hit) check("R8", {29'b0, io_dw_off_o}, {29'b0, ioa[4:2]});
    @(posedge clk_i);
    if (we) begin
      for (int b = 0; b < 4; b++) mk[b*8 +: 8] = {8{be[b]}};
      case (idx)
        6'd1: begin
          if (be[0]) begin m_io = wd[0]; m_par = wd[6]; end
          if (be[3]) m_sts = m_sts & ~wd[31:28];
        end
        6'd3: begin
          if (be[0]) m_cls = wd[7:0];
          if (be[1]) m_lt = wd[15:8];
        end
        6'd4: begin
          full = ({m_base, 5'b0} & ~mk) | (wd & mk);
          m_base = full[31:5];
        end
        default: ;
      endcase
    end
    m_sts = m_sts | ev;
    @(negedge clk_i);
  endtask

  task automatic rd(input logic [5:0] idx, input string tag);
    apply(idx, 1'b0, 4'h0, 32'h0, 4'h0, 1'b0, 30'h0, tag);
  endtask

  task automatic report();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    #(200000 * 5);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    report();
  end

  initial begin
    logic [5:0] idx;
    logic [31:2] a;
    logic [5:0] picks [6];
    ev_ta = 0; ev_ma = 0; ev_se = 0; ev_pe = 0;
    void'($urandom(32'd20240611));
    picks = '{6'd1, 6'd3, 6'd4, 6'd17, 6'd0, 6'd40};

    do_reset(8'hA5);
    // R1 reset state
    rd(6'd1, "R1"); rd(6'd3, "R1"); rd(6'd4, "R1");
    rd(6'd17, "R5");
    // R5 board register ignores writes
    apply(6'd17, 1'b1, 4'hF, 32'hFFFF_FFFF, 4'h0, 1'b0, 30'h0, "R5");
    rd(6'd17, "R5");
    // R3 parity with parity response disabled
    apply(6'd0, 1'b0, 4'h0, 32'h0, 4'b1000, 1'b0, 30'h0, "R10");
    rd(6'd1, "R3");
    // R2 the other three events
    apply(6'd0, 1'b0, 4'h0, 32'h0, 4'b0111, 1'b0, 30'h0, "R10");
    rd(6'd1, "R2");
    // R4 writing zero keeps, writing one clears, event beats clear
    apply(6'd1, 1'b1, 4'h8, 32'h0000_0000, 4'h0, 1'b0, 30'h0, "R4");
    rd(6'd1, "R4");
    apply(6'd1, 1'b1, 4'h8, 32'h3000_0000, 4'b0001, 1'b0, 30'h0, "R4");
    rd(6'd1, "R4");
    apply(6'd1, 1'b1, 4'h7, 32'hF000_0000, 4'h0, 1'b0, 30'h0, "R10");
    rd(6'd1, "R10");
    apply(6'd1, 1'b1, 4'h8, 32'hF000_0000, 4'h0, 1'b0, 30'h0, "R4");
    rd(6'd1, "R4");
    // R9 command bits
    apply(6'd1, 1'b1, 4'hF, 32'h0FFF_FFFF, 4'h0, 1'b0, 30'h0, "R9");
    rd(6'd1, "R9");
    apply(6'd1, 1'b1, 4'h0, 32'h0000_0000, 4'h0, 1'b0, 30'h0, "R10");
    rd(6'd1, "R10");
    // R6 cache line size / latency timer
    apply(6'd3, 1'b1, 4'hF, 32'hFFFF_2010, 4'h0, 1'b0, 30'h0, "R6");
    rd(6'd3, "R6");
    apply(6'd3, 1'b1, 4'h1, 32'h0000_4008, 4'h0, 1'b0, 30'h0, "R10");
    rd(6'd3, "R10");
    // R7 base register
    apply(6'd4, 1'b1, 4'hF, 32'hFFFF_FFFF, 4'h0, 1'b0, 30'h0, "R7");
    rd(6'd4, "R7");
    apply(6'd4, 1'b1, 4'h5, 32'h1234_5600, 4'h0, 1'b0, 30'h0, "R7");
    rd(6'd4, "R7");
    apply(6'd4, 1'b1, 4'hF, 32'hC000_1000, 4'h0, 1'b0, 30'h0, "R7");
    // R8 hit / miss / disabled
    a = 30'(32'hC000_100C >> 2);
    apply(6'd4, 1'b0, 4'h0, 32'h0, 4'h0, 1'b1, a, "R7");
    a = 30'(32'hC000_1020 >> 2);
    apply(6'd4, 1'b0, 4'h0, 32'h0, 4'h0, 1'b1, a, "R8");
    apply(6'd1, 1'b1, 4'h1, 32'h0000_0000, 4'h0, 1'b0, 30'h0, "R9");
    a = 30'(32'hC000_101C >> 2);
    apply(6'd4, 1'b0, 4'h0, 32'h0, 4'h0, 1'b1, a, "R8");
    // R10 unmapped index
    apply(6'd40, 1'b1, 4'hF, 32'hDEAD_BEEF, 4'h0, 1'b0, 30'h0, "R10");
    rd(6'd40, "R10");
    rd(6'd17, "R5");

    // random traffic
    for (int i = 0; i < 4000; i++) begin
      logic [3:0] ev;
      logic [31:0] wd;
      idx = picks[$urandom_range(0, 5)];
      if ($urandom_range(0, 7) == 0) idx = 6'($urandom);
      for (int k = 0; k < 4; k++) ev[k] = ($urandom_range(0, 15) == 0);
      wd = $urandom;
      if (idx == 6'd1 && $urandom_range(0, 1) == 1) wd[0] = 1'b1;
      if (idx == 6'd4) wd[31:12] = 20'hC0001;
      a = {m_base, 3'($urandom)};
      if ($urandom_range(0, 3) == 0) a[31:5] = m_base + 27'd1;
      if ($urandom_range(0, 7) == 0) a = 30'($urandom);
      apply(idx, ($urandom_range(0, 2) == 0), 4'($urandom), wd, ev,
            ($urandom_range(0, 3) != 0), a, "");
    end

    // R5 second reset captures new straps
    do_reset(8'h5A);
    rd(6'd17, "R5");
    rd(6'd1, "R1");
    rd(6'd4, "R1");
    report();
  end
endmodule